// File: doc/BRIEF.md
# Lockstep Master/Checker Pin Comparator

This wrapper sits between a deterministic core and the package pins, so that two identical devices can run in lockstep on one shared bus. A role strap is latched as reset is released and fixes the device as either the master or the checker until the next reset. The master drives its dedicated outputs and bidirectional pins like any normal device. The checker lets go of those pins and compares the levels that the master puts on the bus against what its own core would have driven in the same cycle.

Any disagreement raises a single registered error pin. This pin reports only that something differed, never which signal failed, and no other fault source feeds it. The test-data output is driven in both roles. Read data for the core is always taken from the bus, so both cores consume the same instruction stream. The core is modelled as flat vectors of output values, bidirectional values and bidirectional enables.

The role controller has three states. ST_RESET is entered from any state while `rst` is high. On the first clock edge with `rst` low, ST_RESET moves to ST_CHECKER if the synchronized strap is 1, or to ST_MASTER if it is 0. ST_MASTER and ST_CHECKER hold until reset is asserted again.

Top module: `lockstep_pin_wrapper`

## Requirements
- R1: `strap_chk` passes through a two-stage synchronizer. On the first rising clock edge with `rst` low, the block enters checker role if the synchronized strap is 1 and master role if it is 0. The strap must be stable for at least two clock edges before that edge.
- R2: Once a role is taken, changes on `strap_chk` have no effect on the pin enables until reset is asserted again.
- R3: In master role, `out_en` is 1, `out_drv` equals `core_out`, `bi_en` equals `core_bi_oe` and `bi_drv` equals `core_bi_o`.
- R4: While reset is held and in checker role, `out_en` is 0 and every bit of `bi_en` is 0.
- R5: In checker role, any bit where `out_obs` differs from `core_out` in a cycle sets `err` to 1 after the next rising clock edge.
- R6: In checker role, a bidirectional bit is compared only when its `core_bi_oe` bit is 1. A difference on a bit whose enable is 0 leaves `err` at 0.
- R7: `err` is 0 while reset is held, in the first cycle after release, and at all times in master role, whatever the inputs.
- R8: `err` is a single bit. A difference in several bits gives the same indication as a difference in one bit, and `err` returns to 0 after the first edge that follows a cycle with no difference.
- R9: `core_bi_in` always equals `bi_in`, and `tdo_pin` always equals `core_tdo`, in both roles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; role is latched as it falls |
| strap_chk | input | 1 | Role strap, may be asynchronous; 1 selects checker |
| core_out | input | NO | Values the core wants on its dedicated outputs |
| core_bi_o | input | NB | Values the core wants on bidirectional pins |
| core_bi_oe | input | NB | Per-bit drive request for bidirectional pins |
| core_tdo | input | 1 | Core test-data output |
| core_bi_in | output | NB | Bus value returned to the core |
| out_drv | output | NO | Value for the dedicated output pads |
| out_en | output | 1 | Pad enable for dedicated outputs |
| out_obs | input | NO | Level observed on the dedicated output pins |
| bi_drv | output | NB | Value for the bidirectional pads |
| bi_en | output | NB | Per-bit pad enable for bidirectional pins |
| bi_in | input | NB | Level observed on the bidirectional pins |
| tdo_pin | output | 1 | Test-data output, always driven |
| err | output | 1 | Registered lockstep mismatch flag |

## Verification
The assertions assume that the observed pin levels settle within the same cycle as the core's requests, and that `rst` is synchronous to `clk`. The strap is the only input allowed to move freely. The bench meets these assumptions by changing every input on the falling clock edge and by building the shared bus from the two instances' enables and values. The strap is held steady for several cycles before each reset release. Later strap changes happen only after a role is fixed, which is exactly the case R2 covers.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

    typedef enum logic [1:0] {
        ST_RESET   = 2'd0,
        ST_MASTER  = 2'd1,
        ST_CHECKER = 2'd2
    } role_e;

endpackage

// File: rtl/lockstep_role_fsm.sv
module lockstep_role_fsm
    import lockstep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  strap_chk,
    output role_e role,
    output logic  drive_pins,
    output logic  chk_mode
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    role_e         state_q;
    role_e         state_d;

    // The strap may be asynchronous, so it is resynchronized before use.
    // These stages keep sampling during reset so that they hold a settled value at release.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) sync_q <= strap_chk;
        end else begin : g_many
            always_ff @(posedge clk) sync_q <= {sync_q[LAST-1:0], strap_chk};
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:   state_d = sync_q[LAST] ? ST_CHECKER : ST_MASTER;
            ST_MASTER:  state_d = ST_MASTER;
            ST_CHECKER: state_d = ST_CHECKER;
            default:    state_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RESET;
        else     state_q <= state_d;
    end

    always_comb begin
        drive_pins = 1'b0;
        chk_mode   = 1'b0;
        unique case (state_q)
            ST_RESET:   ;
            ST_MASTER:  drive_pins = 1'b1;
            ST_CHECKER: chk_mode   = 1'b1;
            default:    ;
        endcase
    end

    assign role = state_q;

    // R2
    role_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RESET) |=> $stable(state_q));

endmodule

// File: rtl/lockstep_pin_gate.sv
module lockstep_pin_gate #(
    parameter int NO = 8,
    parameter int NB = 8
) (
    input  logic          drive_pins,
    input  logic [NO-1:0] core_out,
    input  logic [NB-1:0] core_bi_o,
    input  logic [NB-1:0] core_bi_oe,
    input  logic [NB-1:0] bi_in,
    input  logic          core_tdo,
    output logic [NO-1:0] out_drv,
    output logic          out_en,
    output logic [NB-1:0] bi_drv,
    output logic [NB-1:0] bi_en,
    output logic [NB-1:0] core_bi_in,
    output logic          tdo_pin
);

    assign out_drv    = core_out;
    assign out_en     = drive_pins;
    assign bi_drv     = core_bi_o;
    assign bi_en      = core_bi_oe & {NB{drive_pins}};
    assign core_bi_in = bi_in;
    assign tdo_pin    = core_tdo;

endmodule

// File: rtl/lockstep_mismatch.sv
module lockstep_mismatch #(
    parameter int NO = 8,
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chk_mode,
    input  logic [NO-1:0] core_out,
    input  logic [NO-1:0] out_obs,
    input  logic [NB-1:0] core_bi_o,
    input  logic [NB-1:0] core_bi_oe,
    input  logic [NB-1:0] bi_in,
    output logic          err
);

    logic [NB-1:0] bi_hit;
    logic          out_hit;
    logic          err_q;

    genvar i;
    generate
        for (i = 0; i < NB; i++) begin : g_bi
            assign bi_hit[i] = core_bi_oe[i] & (core_bi_o[i] ^ bi_in[i]);
        end
    endgenerate

    assign out_hit = |(core_out ^ out_obs);

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= chk_mode & (out_hit | (|bi_hit));
    end

    assign err = err_q;

    // R7
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_mode |=> !err);

    // R6
    masked_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_mode && (out_obs == core_out) && (((bi_in ^ core_bi_o) & core_bi_oe) == '0)) |=> !err);

endmodule

// File: rtl/lockstep_pin_wrapper.sv
module lockstep_pin_wrapper
    import lockstep_pkg::*;
#(
    parameter int NO          = 8,
    parameter int NB          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap_chk,
    input  logic [NO-1:0] core_out,
    input  logic [NB-1:0] core_bi_o,
    input  logic [NB-1:0] core_bi_oe,
    input  logic          core_tdo,
    output logic [NB-1:0] core_bi_in,
    output logic [NO-1:0] out_drv,
    output logic          out_en,
    input  logic [NO-1:0] out_obs,
    output logic [NB-1:0] bi_drv,
    output logic [NB-1:0] bi_en,
    input  logic [NB-1:0] bi_in,
    output logic          tdo_pin,
    output logic          err
);

    role_e role;
    logic  drive_pins;
    logic  chk_mode;

    lockstep_role_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .strap_chk  (strap_chk),
        .role       (role),
        .drive_pins (drive_pins),
        .chk_mode   (chk_mode)
    );

    lockstep_pin_gate #(.NO(NO), .NB(NB)) u_gate (
        .drive_pins (drive_pins),
        .core_out   (core_out),
        .core_bi_o  (core_bi_o),
        .core_bi_oe (core_bi_oe),
        .bi_in      (bi_in),
        .core_tdo   (core_tdo),
        .out_drv    (out_drv),
        .out_en     (out_en),
        .bi_drv     (bi_drv),
        .bi_en      (bi_en),
        .core_bi_in (core_bi_in),
        .tdo_pin    (tdo_pin)
    );

    lockstep_mismatch #(.NO(NO), .NB(NB)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .chk_mode   (chk_mode),
        .core_out   (core_out),
        .out_obs    (out_obs),
        .core_bi_o  (core_bi_o),
        .core_bi_oe (core_bi_oe),
        .bi_in      (bi_in),
        .err        (err)
    );

    // R4
    float_chk: assert property (@(posedge clk) disable iff (rst)
        (role == ST_CHECKER) |-> (!out_en && (bi_en == '0)));

    // R3
    master_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (role == ST_MASTER) |-> (out_en && (bi_en == core_bi_oe)));

    // R5
    catch_chk: assert property (@(posedge clk) disable iff (rst)
        ((role == ST_CHECKER) && (out_obs != core_out)) |=> err);

endmodule

// File: tb/lockstep_pin_wrapper_bench.sv
`timescale 1ns/1ps
module lockstep_pin_wrapper_bench;

    localparam int NO = 8;
    localparam int NB = 8;

    // Entry: core_out, bi_o, bi_oe, out fault, bi fault, expected err.
    localparam logic [40:0] TBL [0:7] = '{
        {8'h3C, 8'hA5, 8'hFF, 8'h00, 8'h00, 1'b0},
        {8'h3C, 8'hA5, 8'hFF, 8'h01, 8'h00, 1'b1},
        {8'h00, 8'h0F, 8'h0F, 8'h00, 8'h10, 1'b0},
        {8'h00, 8'h0F, 8'h0F, 8'h00, 8'h02, 1'b1},
        {8'hFF, 8'hF0, 8'h00, 8'h00, 8'hFF, 1'b0},
        {8'h81, 8'h00, 8'h00, 8'hC3, 8'h00, 1'b1},
        {8'h81, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0},
        {8'h55, 8'h55, 8'hAA, 8'h80, 8'h80, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic d_strap = 1'b1;
    logic m_strap = 1'b0;
    logic [NO-1:0] c_out = '0;
    logic [NB-1:0] c_bio = '0;
    logic [NB-1:0] c_bioe = '0;
    logic [NO-1:0] f_out = '0;
    logic [NB-1:0] f_bi = '0;
    logic c_tdo = 1'b0;

    logic [NB-1:0] d_bi_in, m_bi_in, d_bi_drv, m_bi_drv, d_bi_en, m_bi_en;
    logic [NO-1:0] d_out_drv, m_out_drv, out_bus;
    logic [NB-1:0] bi_bus;
    logic d_out_en, m_out_en, d_tdo, m_tdo, d_err, m_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign out_bus = m_out_en ? m_out_drv : (d_out_en ? d_out_drv : '0);
    assign bi_bus  = (m_bi_drv & m_bi_en) | (d_bi_drv & d_bi_en & ~m_bi_en);

    lockstep_pin_wrapper #(.NO(NO), .NB(NB)) u_lockstep_pin_wrapper (
        .clk(clk), .rst(rst), .strap_chk(d_strap),
        .core_out(c_out ^ f_out), .core_bi_o(c_bio ^ f_bi), .core_bi_oe(c_bioe),
        .core_tdo(c_tdo), .core_bi_in(d_bi_in), .out_drv(d_out_drv), .out_en(d_out_en),
        .out_obs(out_bus), .bi_drv(d_bi_drv), .bi_en(d_bi_en), .bi_in(bi_bus),
        .tdo_pin(d_tdo), .err(d_err)
    );

    lockstep_pin_wrapper #(.NO(NO), .NB(NB)) u_master (
        .clk(clk), .rst(rst), .strap_chk(m_strap),
        .core_out(c_out), .core_bi_o(c_bio), .core_bi_oe(c_bioe),
        .core_tdo(c_tdo), .core_bi_in(m_bi_in), .out_drv(m_out_drv), .out_en(m_out_en),
        .out_obs(out_bus), .bi_drv(m_bi_drv), .bi_en(m_bi_en), .bi_in(bi_bus),
        .tdo_pin(m_tdo), .err(m_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // Reset state: fault present, nothing driven, no error.
        f_out = 8'h0F;
        repeat (6) @(negedge clk);
        check("R7 err in reset", d_err, 0);
        check("R4 out_en in reset", d_out_en, 0);
        check("R4 bi_en in reset", d_bi_en, 0);
        f_out = '0;
        c_out = 8'h3C; c_bio = 8'hA5; c_bioe = 8'hFF; c_tdo = 1'b1;
        rst = 1'b0;
        @(negedge clk);
        check("R1 checker role out_en", d_out_en, 0);
        check("R1 master role out_en", m_out_en, 1);
        check("R7 err first cycle", d_err, 0);
        check("R3 master out_drv", m_out_drv, 8'h3C);
        check("R3 master bi_en", m_bi_en, 8'hFF);
        check("R3 master bi_drv", m_bi_drv, 8'hA5);
        check("R4 checker bi_en", d_bi_en, 0);
        check("R9 tdo checker", d_tdo, 1);

        // Vector walk in checker role.
        for (int k = 0; k < 8; k++) begin
            {c_out, c_bio, c_bioe, f_out, f_bi} = TBL[k][40:1];
            c_tdo = k[0];
            @(negedge clk);
            check("R5 R6 R8 err vector", d_err, {31'd0, TBL[k][0]});
            check("R7 master err", m_err, 0);
            check("R4 checker float", {d_out_en, d_bi_en}, 0);
            check("R9 core_bi_in", d_bi_in, bi_bus);
            check("R9 tdo_pin", d_tdo, k[0]);
        end
        f_out = '0; f_bi = '0;
        @(negedge clk);
        check("R8 err clears", d_err, 0);

        // Strap changes after role taken are ignored.
        d_strap = 1'b0; m_strap = 1'b1;
        repeat (4) @(negedge clk);
        check("R2 checker holds", d_out_en, 0);
        check("R2 master holds", m_out_en, 1);
        f_out = 8'h10;
        @(negedge clk);
        check("R2 still checking", d_err, 1);

        // Reset clears err even with fault present.
        rst = 1'b1;
        @(negedge clk);
        check("R7 err cleared by reset", d_err, 0);
        m_strap = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 strap low gives master", d_out_en, 1);
        check("R3 second master bi_en", d_bi_en, c_bioe);
        f_out = 8'hFF; f_bi = 8'hFF;
        repeat (3) @(negedge clk);
        check("R7 master ignores fault", d_err, 0);
        check("R3 master out_drv faulty core", d_out_drv, c_out ^ 8'hFF);
        finish_run();
    end

endmodule